// File: doc/BRIEF.md
# Exponential Backoff Retry Pacer

This block sets the pace at which a requester retries a contended atomic compare-and-swap. When a new operation starts it loads a backoff count of 1. Each time the requester reports a failed attempt, the block asks an external stall unit to hold the requester for a time that grows with the count. Once that stall is finished it doubles the count, so repeated failures wait exponentially longer. A success report sends the block back to idle, and the next operation starts again from a count of 1.

The limit test comes before the doubling. A count that is already above the cap of 4096 is kept as it is, and any count at or below the cap is doubled. The count therefore passes the cap once, reaches 8192 and then holds. The block has two stall flavours, chosen for each failure. In pause mode it sends the whole wait to the stall unit as one request of `count << 7` cycles. In legacy mode it issues `count` requests in a row, each for a fixed 128-cycle unit, and waits for each one to finish before it sends the next. Both flavours add up to the same total wait.

Top module: `backoff_pacer`

## Requirements
- R1: After reset the block is idle with `stall_req` low, and `att_fail` has no effect until `op_start` is seen.
- R2: `op_start` loads the backoff count with 1, so the first failure of an operation in pause mode requests 128 cycles.
- R3: After the final stall of each failure completes, the count is doubled if it is not above 4096 and left unchanged otherwise. The pause-mode amounts therefore run 128, 256, ..., 1048576, and 1048576 repeats.
- R4: In pause mode (`mode_pause`=1 when `att_fail` is accepted) one failure produces exactly one request, with `stall_amt` = count × 128.
- R5: In legacy mode (`mode_pause`=0 when `att_fail` is accepted) one failure produces exactly `count` requests, each with `stall_amt` = 128. Each request after the first follows the `stall_done` of the one before it.
- R6: While a stall is outstanding, `att_fail`, `att_ok` and `op_start` are ignored. A failure there creates no request and leaves the count unchanged.
- R7: `att_ok`, when the block is waiting for an outcome, returns it to idle. Later failures create no request until the next `op_start`, which restarts the count at 1.
- R8: `stall_req` is a one-cycle pulse, one cycle after the accepted `att_fail` or `stall_done`. No new request is issued until the outstanding one has been answered by `stall_done`.
- R9: `op_start` while the block is waiting for an outcome reloads the count to 1, whatever its earlier growth. It has priority over `att_ok` and `att_fail` in the same cycle.
- R10: `stall_done` is ignored when no stall is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | Pulse: a new atomic operation begins |
| mode_pause | input | 1 | 1 = single pause request, 0 = legacy unit loop; sampled on an accepted failure |
| att_fail | input | 1 | Pulse: the last attempt failed |
| att_ok | input | 1 | Pulse: the last attempt succeeded |
| stall_done | input | 1 | Pulse from the stall unit: the current request has completed |
| stall_req | output | 1 | One-cycle pulse: start a stall |
| stall_amt | output | 21 | Stall length in cycles, valid with `stall_req` |

## Verification
The hardest state to reach from the ports is the saturated count in legacy mode. To get there the block must pass every doubling level, and at each level it must loop through as many unit requests as the count holds, with each request answered before the next one goes out. The bench runs a full legacy sweep of fifteen failures and answers every unit request as it arrives, which takes about 24575 handshakes. It confirms the unit total at each level, including the repeat at 8192. A matching pause-mode sweep checks the same levels as single amounts. Failure and completion pulses are sent while a stall is outstanding or while the block is idle, to show that they are ignored.

// File: rtl/backoff_pkg.sv
package backoff_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_ISSUE = 2'd2,
        ST_WAIT  = 2'd3
    } bo_state_e;

endpackage

// File: rtl/bo_grow.sv
// Next backoff count: the limit test is made before doubling, so the count
// steps past the cap once and then holds there.
module bo_grow #(
    parameter int CNT_W = 14,
    parameter int CAP   = 4096
) (
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAP);

    always_comb begin
        if (cnt_i > CAP_V) begin
            cnt_o = cnt_i;
        end else begin
            cnt_o = cnt_i << 1;
        end
    end
endmodule

// File: rtl/bo_amount.sv
// Stall amount for the first request of a failure: the whole scaled count in
// pause mode, or a single fixed unit in legacy mode.
module bo_amount #(
    parameter int CNT_W = 14,
    parameter int SHIFT = 7,
    localparam int AMT_W = CNT_W + SHIFT
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             pause_i,
    output logic [AMT_W-1:0] amt_o
);
    localparam logic [AMT_W-1:0] UNIT_V = AMT_W'(1) << SHIFT;

    always_comb begin
        if (pause_i) begin
            amt_o = {cnt_i, {SHIFT{1'b0}}};
        end else begin
            amt_o = UNIT_V;
        end
    end
endmodule

// File: rtl/backoff_pacer.sv
module backoff_pacer
    import backoff_pkg::*;
#(
    parameter int CAP   = 4096,
    parameter int SHIFT = 7,
    parameter int START = 1,
    localparam int CNT_W = $clog2(CAP) + 2,
    localparam int AMT_W = CNT_W + SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_start,
    input  logic             mode_pause,
    input  logic             att_fail,
    input  logic             att_ok,
    input  logic             stall_done,
    output logic             stall_req,
    output logic [AMT_W-1:0] stall_amt
);
    localparam logic [CNT_W-1:0] START_V = CNT_W'(START);

    typedef struct packed {
        bo_state_e        st;
        logic [CNT_W-1:0] cnt;   // backoff count
        logic [CNT_W-1:0] left;  // legacy units still to issue
        logic             pause; // mode latched for this failure
        logic [AMT_W-1:0] amt;   // amount presented with the request
    } regs_t;

    regs_t r_d, r_q;

    logic [CNT_W-1:0] cnt_grown;
    logic [AMT_W-1:0] amt_first;

    bo_grow #(
        .CNT_W(CNT_W),
        .CAP  (CAP)
    ) u_grow (
        .cnt_i(r_q.cnt),
        .cnt_o(cnt_grown)
    );

    bo_amount #(
        .CNT_W(CNT_W),
        .SHIFT(SHIFT)
    ) u_amount (
        .cnt_i  (r_q.cnt),
        .pause_i(mode_pause),
        .amt_o  (amt_first)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (op_start) begin
                    r_d.st  = ST_ARMED;
                    r_d.cnt = START_V;
                end
            end
            ST_ARMED: begin
                if (op_start) begin
                    r_d.cnt = START_V;
                end else if (att_ok) begin
                    r_d.st = ST_IDLE;
                end else if (att_fail) begin
                    r_d.st    = ST_ISSUE;
                    r_d.pause = mode_pause;
                    r_d.amt   = amt_first;
                    r_d.left  = r_q.cnt - CNT_W'(1);
                end
            end
            ST_ISSUE: begin
                r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (stall_done) begin
                    if (!r_q.pause && (r_q.left != '0)) begin
                        r_d.left = r_q.left - CNT_W'(1);
                        r_d.st   = ST_ISSUE;
                    end else begin
                        r_d.cnt = cnt_grown;
                        r_d.st  = ST_ARMED;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.cnt   <= START_V;
            r_q.left  <= '0;
            r_q.pause <= 1'b0;
            r_q.amt   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign stall_req = (r_q.st == ST_ISSUE);
    assign stall_amt = r_q.amt;

endmodule

// File: rtl/backoff_pacer_chk.sv
module backoff_pacer_chk #(
    parameter int CAP   = 4096,
    parameter int SHIFT = 7,
    parameter int AMT_W = 21
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_pause,
    input logic             att_fail,
    input logic             stall_done,
    input logic             stall_req,
    input logic [AMT_W-1:0] stall_amt
);
    localparam logic [AMT_W-1:0] UNIT_V = AMT_W'(1) << SHIFT;
    localparam logic [AMT_W-1:0] MAX_V  = AMT_W'(2 * CAP) << SHIFT;

    logic outst_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst_q <= 1'b0;
        end else if (stall_req) begin
            outst_q <= 1'b1;
        end else if (stall_done) begin
            outst_q <= 1'b0;
        end
    end

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |=> !stall_req); // R8
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |-> !outst_q); // R8
    AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |-> $past(att_fail || stall_done)); // R6
    AST_AMT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |-> (stall_amt <= MAX_V)); // R3
    AST_PAUSE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_req && $past(att_fail && mode_pause))
            |-> ($countones(stall_amt) == 1 && stall_amt >= UNIT_V)); // R4
    AST_LEGACY_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_req && $past(att_fail && !mode_pause)) |-> (stall_amt == UNIT_V)); // R5

endmodule

bind backoff_pacer backoff_pacer_chk #(
    .CAP  (CAP),
    .SHIFT(SHIFT),
    .AMT_W(AMT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_pause(mode_pause),
    .att_fail  (att_fail),
    .stall_done(stall_done),
    .stall_req (stall_req),
    .stall_amt (stall_amt)
);

// File: tb/tb_backoff_pacer.sv
`timescale 1ns/1ps
module tb_backoff_pacer;
    localparam int CAP   = 4096;
    localparam int SHIFT = 7;
    localparam int AMT_W = 21;
    localparam int UNIT  = 1 << SHIFT;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             op_start = 1'b0;
    logic             mode_pause = 1'b1;
    logic             att_fail = 1'b0;
    logic             att_ok = 1'b0;
    logic             stall_done = 1'b0;
    logic             stall_req;
    logic [AMT_W-1:0] stall_amt;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit ended  = 1'b0;
    int model_cnt;

    backoff_pacer dut (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .mode_pause(mode_pause),
        .att_fail(att_fail), .att_ok(att_ok), .stall_done(stall_done),
        .stall_req(stall_req), .stall_amt(stall_amt)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            finish_run();
        end
    end

    function automatic int grow(input int c);
        return (c > CAP) ? c : 2 * c;
    endfunction

    task automatic pulse_start();
        @(negedge clk); op_start = 1'b1;
        @(negedge clk); op_start = 1'b0;
        model_cnt = 1;
    endtask

    // One pause-mode failure; a fail and a start are sent during the stall.
    task automatic fail_pause(input string req);
        @(negedge clk); mode_pause = 1'b1; att_fail = 1'b1;
        @(negedge clk); att_fail = 1'b0;
        chk(stall_req == 1'b1, "R8", stall_req, 1);
        chk(stall_amt == AMT_W'(model_cnt * UNIT), req, stall_amt, model_cnt * UNIT);
        @(negedge clk);
        chk(stall_req == 1'b0, "R8", stall_req, 0);
        att_fail = 1'b1; op_start = 1'b1;
        @(negedge clk); att_fail = 1'b0; op_start = 1'b0;
        chk(stall_req == 1'b0, "R6", stall_req, 0);
        stall_done = 1'b1;
        @(negedge clk); stall_done = 1'b0;
        chk(stall_req == 1'b0, "R4", stall_req, 0);
        model_cnt = grow(model_cnt);
    endtask

    // One legacy-mode failure; every unit request is answered as it arrives.
    task automatic fail_legacy(input string req);
        int n = 0;
        int bad = 0;
        @(negedge clk); mode_pause = 1'b0; att_fail = 1'b1;
        @(negedge clk); att_fail = 1'b0;
        while (stall_req && n < 20000) begin
            if (stall_amt != AMT_W'(UNIT)) bad++;
            n++;
            @(negedge clk);
            if (stall_req) bad++;
            stall_done = 1'b1;
            @(negedge clk); stall_done = 1'b0;
        end
        chk(bad == 0, "R5", bad, 0);
        chk(n == model_cnt, req, n, model_cnt);
        model_cnt = grow(model_cnt);
        mode_pause = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(stall_req == 1'b0, "R1", stall_req, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(stall_req == 1'b0, "R1", stall_req, 0);

        // fail and done while idle, before any start
        att_fail = 1'b1; stall_done = 1'b1;
        @(negedge clk); att_fail = 1'b0; stall_done = 1'b0;
        @(negedge clk);
        chk(stall_req == 1'b0, "R1", stall_req, 0);

        // pause-mode sweep up to and past the cap
        pulse_start();
        fail_pause("R2");
        for (int k = 1; k < 16; k++) fail_pause("R3");

        // stray done while waiting for an outcome
        @(negedge clk); stall_done = 1'b1;
        @(negedge clk); stall_done = 1'b0;
        chk(stall_req == 1'b0, "R10", stall_req, 0);
        fail_pause("R10");

        // success returns to idle
        @(negedge clk); att_ok = 1'b1;
        @(negedge clk); att_ok = 1'b0;
        att_fail = 1'b1;
        @(negedge clk); att_fail = 1'b0;
        @(negedge clk);
        chk(stall_req == 1'b0, "R7", stall_req, 0);
        pulse_start();
        fail_pause("R7");

        // reload in the middle of growth, start beats fail in the same cycle
        fail_pause("R3");
        fail_pause("R3");
        @(negedge clk); op_start = 1'b1; att_fail = 1'b1;
        @(negedge clk); op_start = 1'b0; att_fail = 1'b0;
        chk(stall_req == 1'b0, "R9", stall_req, 0);
        model_cnt = 1;
        fail_pause("R9");

        // legacy sweep from a fresh start, through the saturated count
        pulse_start();
        for (int k = 0; k < 15; k++) fail_legacy("R5");

        // switching back to pause shows the saturated count
        fail_pause("R3");
        // a legacy failure at the cap still takes the capped unit total
        fail_legacy("R3");
        finish_run();
    end
endmodule